// File: doc/BRIEF.md
# Ingress Request and Eager-Send Controller

This block sits at one ingress port of a multistage switch and decides, once per cell time, which virtual output queue may act. Each queue reaches the fabric in one of two ways. It can ask permission first: it sends a request toward its output and waits for a grant. Or it can send eagerly, without a grant, while a quota shared by the whole port has room. Returning acknowledgements refill that quota. Per-output congestion notifications stop new eager cells toward outputs that are marked busy.

Each cycle the block offers at most one request and at most one cell dispatch. Both come with a queue index and a middle-stage route. Each offer is a valid/ready stream. The valid signal and its payload depend only on registered state and on the current inputs, never on ready. An offer is committed, and its state updated, only in a cycle where valid and ready are both high. While ready is low nothing changes, and the offer may be re-chosen later if the inputs change.

Grants, acknowledgements and notifications are plain single-cycle pulses. Three limits are runtime inputs: the eager quota U, the outstanding-request bound u and the round-trip time. Cell storage and the data path are outside the block.

Top module: `vq_ingress_ctl`

## Requirements
- R1: After reset every per-queue count is zero. A request for a queue is offered only while that queue's pending plus granted count is below `cfg_req_max` (u). Its pending count rises by one when a request is accepted and falls by one when a grant for that queue arrives. Both events in the same cycle leave the count unchanged.
- R2: The route of a queue's requests starts at 0. It advances by one for each accepted request of that queue and wraps from NR-1 back to 0.
- R3: A grant adds one to the queue's granted count. A granted cell (`cell_eager`=0) is offered only for a non-empty queue with a nonzero granted count, and only when `xp_credit[r]` is 1 for that queue's cell route r. The cell route starts at 0 and advances by one, with wrap, on every accepted dispatch of that queue, granted or eager.
- R4: A shared eager count rises by one on each accepted eager dispatch (`cell_eager`=1) and falls by one on each `ack_valid` pulse while it is nonzero. An eager cell is offered only while this count is below `cfg_eager_max` (U).
- R5: A queue is eager-eligible only if all of these hold: it is non-empty, it has zero pending and zero granted, and its head age is below `cfg_rtt + floor(cfg_rtt/2)`.
- R6: A queue that is eager-eligible never offers a request.
- R7: While an output's congested flag is 1, its queue is not eager-eligible, and it falls back to requests.
- R8: A notification has a kind: `cn_set`=1 means set, 0 means clear. A set on an unmarked output marks it. A clear on a marked output unmarks it. A set on a marked output unmarks it, and a clear on an unmarked output marks it.
- R9: When some queue can send a granted cell, no eager cell is offered in that cycle.
- R10: Requests and cells each keep their own round-robin pointer. The search starts one index past the last accepted queue, and the pointer is 0 after reset.
- R11: A grant for a queue whose pending count is zero is dropped and leaves its granted count unchanged.
- R12: While `req_ready` or `cell_ready` is low, the matching offer commits nothing. Routes, counts and pointers are unchanged afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one cell time per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_eager_max | input | EW | Eager quota U |
| cfg_req_max | input | CW | Outstanding-request bound u |
| cfg_rtt | input | AW | Round-trip time in cycles |
| q_nonempty | input | NQ | Queue holds at least one cell, one bit per queue |
| hol_age | input | NQ*AW | Head cell age per queue, queue q at bits q*AW and up |
| xp_credit | input | NR | Downstream crosspoint credit available, one bit per route |
| grant_valid | input | 1 | Grant arrival pulse |
| grant_q | input | QW | Queue the grant belongs to |
| ack_valid | input | 1 | Eager-cell acknowledgement pulse |
| cn_valid | input | 1 | Congestion notification pulse |
| cn_out | input | QW | Output the notification concerns |
| cn_set | input | 1 | Notification kind, 1 = set, 0 = clear |
| req_valid | output | 1 | Request offered |
| req_ready | input | 1 | Request accepted when high with req_valid |
| req_q | output | QW | Requesting queue |
| req_route | output | RW | Route of the request |
| cell_valid | output | 1 | Cell dispatch offered |
| cell_ready | input | 1 | Dispatch accepted when high with cell_valid |
| cell_q | output | QW | Dispatching queue |
| cell_route | output | RW | Route of the cell |
| cell_eager | output | 1 | 1 = eager cell, 0 = granted cell |

## Verification
Two coincidences matter most. The first is a grant arriving for a queue in the same cycle that the queue's next request is accepted. The bench drives that pulse while the request is being taken. It then judges the net pending count by whether the granted cell is offered, and whether the bound stops the following request. The second is one queue holding a grant while another queue is eager-eligible in the same cycle. The bench first stalls both streams to show that nothing is consumed, then releases them and expects the granted cell first and the untouched eager cell next.

// File: rtl/vq_ingress_pkg.sv
package vq_ingress_pkg;

  typedef enum logic {
    SEND_GRANTED = 1'b0,
    SEND_EAGER   = 1'b1
  } send_kind_e;

  // Next index of a rotating pointer over lim positions.
  function automatic int wrap_next(input int cur, input int lim);
    return (cur + 1 >= lim) ? 0 : cur + 1;
  endfunction

endpackage

// File: rtl/vq_rr_pick.sv
module vq_rr_pick #(
  parameter int N = 4,
  localparam int IW = $clog2(N)
) (
  input  logic [N-1:0]  cand,
  input  logic [IW-1:0] ptr,
  output logic          hit,
  output logic [IW-1:0] idx
);

  // First candidate at or after ptr, searching upward with wrap.
  always_comb begin
    hit = 1'b0;
    idx = '0;
    for (int k = 0; k < N; k++) begin
      if (!hit && cand[(int'(ptr) + k) % N]) begin
        hit = 1'b1;
        idx = IW'((int'(ptr) + k) % N);
      end
    end
  end

endmodule

// File: rtl/vq_cong_flags.sv
module vq_cong_flags #(
  parameter int NQ = 4,
  localparam int QW = $clog2(NQ)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cn_valid,
  input  logic [QW-1:0] cn_out,
  input  logic          cn_set,
  output logic [NQ-1:0] congested
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      congested <= '0;
    end else begin
      for (int q = 0; q < NQ; q++) begin
        if (cn_valid && cn_out == QW'(q)) begin
          // Notifications may be reordered: a repeat of the present
          // state flips it, a change of state applies it.
          unique case ({cn_set, congested[q]})
            2'b10:   congested[q] <= 1'b1;
            2'b11:   congested[q] <= 1'b0;
            2'b00:   congested[q] <= 1'b1;
            default: congested[q] <= 1'b0;
          endcase
        end
      end
    end
  end

endmodule

// File: rtl/vq_flow_slot.sv
module vq_flow_slot
  import vq_ingress_pkg::*;
#(
  parameter int NR = 4,
  parameter int CW = 3,
  parameter int AW = 8,
  localparam int RW = $clog2(NR)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          nonempty,
  input  logic [AW-1:0] age,
  input  logic [AW:0]   age_lim,
  input  logic [CW-1:0] req_max,
  input  logic          congested,
  input  logic          share_ok,
  input  logic [NR-1:0] xp_credit,
  input  logic          grant_hit,
  input  logic          req_take,
  input  logic          take_granted,
  input  logic          take_eager,
  output logic          req_ok,
  output logic          eager_ok,
  output logic          gdisp_ok,
  output logic          edisp_ok,
  output logic [RW-1:0] req_route,
  output logic [RW-1:0] cell_route,
  output logic [CW-1:0] pend,
  output logic [CW-1:0] gcnt
);

  logic          grant_eff;
  logic [CW:0]   outstanding;
  logic          credit_here;
  logic [RW-1:0] rptr;
  logic [RW-1:0] cptr;

  // A grant with nothing pending is stray and dropped.
  assign grant_eff   = grant_hit && (pend != '0);
  assign outstanding = {1'b0, pend} + {1'b0, gcnt};
  assign credit_here = xp_credit[cptr];

  assign eager_ok = nonempty && (pend == '0) && (gcnt == '0) &&
                    ({1'b0, age} < age_lim) && !congested && share_ok;
  assign req_ok   = nonempty && (outstanding < {1'b0, req_max}) && !eager_ok;
  assign gdisp_ok = nonempty && (gcnt != '0) && credit_here;
  assign edisp_ok = eager_ok && credit_here;

  assign req_route  = rptr;
  assign cell_route = cptr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend <= '0;
      gcnt <= '0;
      rptr <= '0;
      cptr <= '0;
    end else begin
      pend <= pend + CW'(req_take) - CW'(grant_eff);
      gcnt <= gcnt + CW'(grant_eff) - CW'(take_granted);
      if (req_take) begin
        rptr <= RW'(wrap_next(int'(rptr), NR));
      end
      if (take_granted || take_eager) begin
        cptr <= RW'(wrap_next(int'(cptr), NR));
      end
    end
  end

endmodule

// File: rtl/vq_ingress_ctl.sv
module vq_ingress_ctl
  import vq_ingress_pkg::*;
#(
  parameter int NQ = 4,
  parameter int NR = 4,
  parameter int CW = 3,
  parameter int EW = 4,
  parameter int AW = 8,
  localparam int QW = $clog2(NQ),
  localparam int RW = $clog2(NR)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [EW-1:0]    cfg_eager_max,
  input  logic [CW-1:0]    cfg_req_max,
  input  logic [AW-1:0]    cfg_rtt,
  input  logic [NQ-1:0]    q_nonempty,
  input  logic [NQ*AW-1:0] hol_age,
  input  logic [NR-1:0]    xp_credit,
  input  logic             grant_valid,
  input  logic [QW-1:0]    grant_q,
  input  logic             ack_valid,
  input  logic             cn_valid,
  input  logic [QW-1:0]    cn_out,
  input  logic             cn_set,
  output logic             req_valid,
  input  logic             req_ready,
  output logic [QW-1:0]    req_q,
  output logic [RW-1:0]    req_route,
  output logic             cell_valid,
  input  logic             cell_ready,
  output logic [QW-1:0]    cell_q,
  output logic [RW-1:0]    cell_route,
  output logic             cell_eager
);

  logic [AW:0]     age_lim;
  logic [EW-1:0]   ecnt;
  logic            share_ok;
  logic [NQ-1:0]   cong_vec;
  logic [NQ-1:0]   req_vec;
  logic [NQ-1:0]   eager_vec;
  logic [NQ-1:0]   gdisp_vec;
  logic [NQ-1:0]   edisp_vec;
  logic [RW-1:0]   rroute [NQ];
  logic [RW-1:0]   croute [NQ];
  logic [NQ*CW-1:0] pend_flat;
  logic [NQ*CW-1:0] gnt_flat;
  logic [QW-1:0]   req_ptr;
  logic [QW-1:0]   cell_ptr;
  logic            g_hit;
  logic            e_hit;
  logic [QW-1:0]   g_idx;
  logic [QW-1:0]   e_idx;
  send_kind_e      kind;
  logic            req_fire;
  logic            cell_fire;
  logic            eager_fire;
  logic            ack_dec;

  // Age limit is one and a half round-trip times.
  assign age_lim  = {1'b0, cfg_rtt} + {2'b00, cfg_rtt[AW-1:1]};
  assign share_ok = ecnt < cfg_eager_max;

  vq_cong_flags #(.NQ(NQ)) u_cong (
    .clk       (clk),
    .rst_n     (rst_n),
    .cn_valid  (cn_valid),
    .cn_out    (cn_out),
    .cn_set    (cn_set),
    .congested (cong_vec)
  );

  for (genvar g = 0; g < NQ; g++) begin : g_slot
    vq_flow_slot #(.NR(NR), .CW(CW), .AW(AW)) u_slot (
      .clk          (clk),
      .rst_n        (rst_n),
      .nonempty     (q_nonempty[g]),
      .age          (hol_age[g*AW +: AW]),
      .age_lim      (age_lim),
      .req_max      (cfg_req_max),
      .congested    (cong_vec[g]),
      .share_ok     (share_ok),
      .xp_credit    (xp_credit),
      .grant_hit    (grant_valid && grant_q == QW'(g)),
      .req_take     (req_fire && req_q == QW'(g)),
      .take_granted (cell_fire && !cell_eager && cell_q == QW'(g)),
      .take_eager   (eager_fire && cell_q == QW'(g)),
      .req_ok       (req_vec[g]),
      .eager_ok     (eager_vec[g]),
      .gdisp_ok     (gdisp_vec[g]),
      .edisp_ok     (edisp_vec[g]),
      .req_route    (rroute[g]),
      .cell_route   (croute[g]),
      .pend         (pend_flat[g*CW +: CW]),
      .gcnt         (gnt_flat[g*CW +: CW])
    );
  end

  vq_rr_pick #(.N(NQ)) u_req_pick (
    .cand (req_vec),
    .ptr  (req_ptr),
    .hit  (req_valid),
    .idx  (req_q)
  );

  vq_rr_pick #(.N(NQ)) u_gnt_pick (
    .cand (gdisp_vec),
    .ptr  (cell_ptr),
    .hit  (g_hit),
    .idx  (g_idx)
  );

  vq_rr_pick #(.N(NQ)) u_eag_pick (
    .cand (edisp_vec),
    .ptr  (cell_ptr),
    .hit  (e_hit),
    .idx  (e_idx)
  );

  // Granted cells take precedence over eager ones.
  assign kind       = g_hit ? SEND_GRANTED : SEND_EAGER;
  assign cell_valid = g_hit || e_hit;
  assign cell_q     = g_hit ? g_idx : e_idx;
  assign cell_eager = cell_valid && (kind == SEND_EAGER);
  assign cell_route = croute[cell_q];
  assign req_route  = rroute[req_q];

  assign req_fire   = req_valid && req_ready;
  assign cell_fire  = cell_valid && cell_ready;
  assign eager_fire = cell_fire && cell_eager;
  assign ack_dec    = ack_valid && (ecnt != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_ptr  <= '0;
      cell_ptr <= '0;
      ecnt     <= '0;
    end else begin
      if (req_fire) begin
        req_ptr <= QW'(wrap_next(int'(req_q), NQ));
      end
      if (cell_fire) begin
        cell_ptr <= QW'(wrap_next(int'(cell_q), NQ));
      end
      unique case ({eager_fire, ack_dec})
        2'b10:   ecnt <= ecnt + EW'(1);
        2'b01:   ecnt <= ecnt - EW'(1);
        default: ecnt <= ecnt;
      endcase
    end
  end

endmodule

// File: rtl/vq_ingress_chk.sv
module vq_ingress_chk #(
  parameter int NQ = 4,
  parameter int NR = 4,
  parameter int CW = 3,
  parameter int EW = 4,
  localparam int QW = $clog2(NQ),
  localparam int RW = $clog2(NR)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic [QW-1:0]    req_q,
  input logic             cell_valid,
  input logic             cell_eager,
  input logic [QW-1:0]    cell_q,
  input logic [RW-1:0]    cell_route,
  input logic [NR-1:0]    xp_credit,
  input logic [EW-1:0]    cfg_eager_max,
  input logic [CW-1:0]    cfg_req_max,
  input logic [EW-1:0]    ecnt,
  input logic [NQ*CW-1:0] pend_flat,
  input logic [NQ*CW-1:0] gnt_flat,
  input logic [NQ-1:0]    cong_vec,
  input logic [NQ-1:0]    eager_vec,
  input logic [NQ-1:0]    gdisp_vec
);

  // R1
  req_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> (pend_flat[req_q*CW +: CW] < cfg_req_max));

  // R6
  req_not_eager_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> !eager_vec[req_q]);

  // R3
  cell_credit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cell_valid |-> xp_credit[cell_route]);

  // R4
  eager_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cell_valid && cell_eager) |-> (ecnt < cfg_eager_max));

  // R5
  eager_ungranted_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cell_valid && cell_eager) |->
      (gnt_flat[cell_q*CW +: CW] == '0 && pend_flat[cell_q*CW +: CW] == '0));

  // R7
  cong_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cell_valid && cell_eager) |-> !cong_vec[cell_q]);

  // R9
  granted_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cell_valid && cell_eager) |-> (gdisp_vec == '0));

endmodule

bind vq_ingress_ctl vq_ingress_chk #(.NQ(NQ), .NR(NR), .CW(CW), .EW(EW)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .req_valid     (req_valid),
  .req_q         (req_q),
  .cell_valid    (cell_valid),
  .cell_eager    (cell_eager),
  .cell_q        (cell_q),
  .cell_route    (cell_route),
  .xp_credit     (xp_credit),
  .cfg_eager_max (cfg_eager_max),
  .cfg_req_max   (cfg_req_max),
  .ecnt          (ecnt),
  .pend_flat     (pend_flat),
  .gnt_flat      (gnt_flat),
  .cong_vec      (cong_vec),
  .eager_vec     (eager_vec),
  .gdisp_vec     (gdisp_vec)
);

// File: tb/tb_vq_ingress_ctl.sv
module tb_vq_ingress_ctl;
  localparam int NQ = 4;
  localparam int NR = 4;
  localparam int CW = 3;
  localparam int EW = 4;
  localparam int AW = 8;
  localparam int QW = 2;
  localparam int RW = 2;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic             rst_n;
  logic [EW-1:0]    cfg_eager_max;
  logic [CW-1:0]    cfg_req_max;
  logic [AW-1:0]    cfg_rtt;
  logic [NQ-1:0]    q_nonempty;
  logic [NQ*AW-1:0] hol_age;
  logic [NR-1:0]    xp_credit;
  logic             grant_valid;
  logic [QW-1:0]    grant_q;
  logic             ack_valid;
  logic             cn_valid;
  logic [QW-1:0]    cn_out;
  logic             cn_set;
  logic             req_valid;
  logic             req_ready;
  logic [QW-1:0]    req_q;
  logic [RW-1:0]    req_route;
  logic             cell_valid;
  logic             cell_ready;
  logic [QW-1:0]    cell_q;
  logic [RW-1:0]    cell_route;
  logic             cell_eager;

  vq_ingress_ctl #(.NQ(NQ), .NR(NR), .CW(CW), .EW(EW), .AW(AW)) dut (.*);

  int    checks = 0;
  int    fails  = 0;
  bit    done   = 1'b0;
  int    exp_req[$];
  string exp_req_tag[$];
  int    exp_cell[$];
  string exp_cell_tag[$];
  int    m_exp;
  string m_tag;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Scoreboard driver side: expected request as q*16+route.
  task automatic push_req(input int q, input int r, input string tag);
    exp_req.push_back(q * 16 + r);
    exp_req_tag.push_back(tag);
  endtask

  // Expected cell as q*16+route*2+eager.
  task automatic push_cell(input int q, input int r, input int e, input string tag);
    exp_cell.push_back(q * 16 + r * 2 + e);
    exp_cell_tag.push_back(tag);
  endtask

  // Monitor: every accepted transfer must match the next expectation.
  always @(negedge clk) begin
    if (rst_n && req_valid && req_ready) begin
      if (exp_req.size() == 0) begin
        chk(1'b0, "R2 unexpected request", int'(req_q) * 16 + int'(req_route), -1);
      end else begin
        m_exp = exp_req.pop_front();
        m_tag = exp_req_tag.pop_front();
        chk(int'(req_q) * 16 + int'(req_route) == m_exp, m_tag,
            int'(req_q) * 16 + int'(req_route), m_exp);
      end
    end
    if (rst_n && cell_valid && cell_ready) begin
      if (exp_cell.size() == 0) begin
        chk(1'b0, "R3 unexpected cell",
            int'(cell_q) * 16 + int'(cell_route) * 2 + int'(cell_eager), -1);
      end else begin
        m_exp = exp_cell.pop_front();
        m_tag = exp_cell_tag.pop_front();
        chk(int'(cell_q) * 16 + int'(cell_route) * 2 + int'(cell_eager) == m_exp, m_tag,
            int'(cell_q) * 16 + int'(cell_route) * 2 + int'(cell_eager), m_exp);
      end
    end
  end

  task automatic step();
    @(posedge clk);
    #1;
    grant_valid = 1'b0;
    ack_valid   = 1'b0;
    cn_valid    = 1'b0;
  endtask

  task automatic drain(input string scen);
    chk(exp_req.size() == 0, {"R2 missing request ", scen}, exp_req.size(), 0);
    chk(exp_cell.size() == 0, {"R3 missing cell ", scen}, exp_cell.size(), 0);
    exp_req.delete();
    exp_req_tag.delete();
    exp_cell.delete();
    exp_cell_tag.delete();
  endtask

  task automatic do_reset(input int u_eager, input int u_req, input int rtt);
    rst_n         = 1'b0;
    cfg_eager_max = EW'(u_eager);
    cfg_req_max   = CW'(u_req);
    cfg_rtt       = AW'(rtt);
    q_nonempty    = '0;
    hol_age       = '0;
    xp_credit     = '1;
    grant_valid   = 1'b0;
    grant_q       = '0;
    ack_valid     = 1'b0;
    cn_valid      = 1'b0;
    cn_out        = '0;
    cn_set        = 1'b0;
    req_ready     = 1'b0;
    cell_ready    = 1'b0;
    repeat (2) @(posedge clk);
    #1;
    rst_n = 1'b1;
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  initial begin
    #(20 * 20000);
    if (!done) begin
      fails++;
      $display("FAIL R1 watchdog actual=timeout expected=finish");
      summary();
      $finish;
    end
  end

  initial begin
    // Scenario 1: eager quota, fallback to requests, grant, dispatch.
    do_reset(2, 2, 8);
    #4;
    chk(!req_valid, "R1 reset request idle", req_valid, 0);
    chk(!cell_valid, "R4 reset cell idle", cell_valid, 0);
    q_nonempty = 4'b0001;
    req_ready  = 1'b1;
    cell_ready = 1'b1;
    push_cell(0, 0, 1, "R5 first eager cell");
    step();
    push_cell(0, 1, 1, "R3 cell route advances");
    step();
    push_req(0, 0, "R4 quota used, request instead");
    step();
    push_req(0, 1, "R2 request route rotates");
    step();
    ack_valid = 1'b1;
    #4;
    chk(!req_valid, "R1 pending at bound", req_valid, 0);
    chk(!cell_valid, "R5 pending blocks eager", cell_valid, 0);
    step();
    grant_valid = 1'b1;
    grant_q     = 2'd0;
    #4;
    chk(!cell_valid, "R3 no cell before grant registers", cell_valid, 0);
    step();
    #4;
    chk(!req_valid, "R1 pending plus granted at bound", req_valid, 0);
    push_cell(0, 2, 0, "R3 granted dispatch");
    step();
    push_req(0, 2, "R2 third request route");
    step();
    q_nonempty = '0;
    step();
    drain("S1");

    // Scenario 2: granted versus eager in one cycle, with back-pressure.
    do_reset(0, 2, 8);
    q_nonempty = 4'b0100;
    req_ready  = 1'b1;
    push_req(2, 0, "R6 request while eager disabled");
    step();
    cfg_eager_max = 4'd2;
    q_nonempty    = 4'b0110;
    req_ready     = 1'b0;
    grant_valid   = 1'b1;
    grant_q       = 2'd2;
    #4;
    chk(cell_valid && cell_eager && cell_q == 2'd1, "R12 eager offered while stalled",
        int'(cell_q), 1);
    chk(req_valid && req_q == 2'd2, "R6 request from non-eager queue", int'(req_q), 2);
    step();
    req_ready  = 1'b1;
    cell_ready = 1'b1;
    push_cell(2, 0, 0, "R9 granted before eager");
    push_req(2, 1, "R12 stalled request left route unchanged");
    step();
    push_cell(1, 0, 1, "R12 stalled eager cell not consumed");
    push_req(2, 2, "R2 request route after stall");
    step();
    q_nonempty = '0;
    step();
    drain("S2");

    // Scenario 3: round robin and acknowledgement refill.
    do_reset(4, 2, 8);
    q_nonempty = 4'b1111;
    cell_ready = 1'b1;
    for (int q = 0; q < NQ; q++) begin
      push_cell(q, 0, 1, "R10 round robin order");
      step();
    end
    q_nonempty = 4'b0001;
    ack_valid  = 1'b1;
    #4;
    chk(!cell_valid, "R4 quota exhausted", cell_valid, 0);
    step();
    push_cell(0, 1, 1, "R4 acknowledgement frees quota");
    step();
    q_nonempty = '0;
    step();
    drain("S3");

    // Scenario 4: congestion flags and age limit, no ready.
    do_reset(2, 2, 8);
    cn_valid = 1'b1;
    cn_out   = 2'd0;
    cn_set   = 1'b1;
    step();
    q_nonempty = 4'b0001;
    #4;
    chk(!cell_valid, "R7 congested output sends no eager cell", cell_valid, 0);
    chk(req_valid && req_q == 2'd0, "R7 congested queue requests", req_valid, 1);
    cn_valid = 1'b1;
    cn_out   = 2'd0;
    cn_set   = 1'b1;
    step();
    #4;
    chk(cell_valid && cell_eager && cell_q == 2'd0, "R8 repeated set clears flag",
        cell_valid, 1);
    cn_valid = 1'b1;
    cn_out   = 2'd1;
    cn_set   = 1'b0;
    step();
    q_nonempty = 4'b0010;
    #4;
    chk(!cell_valid, "R8 clear on unmarked output marks it", cell_valid, 0);
    step();
    q_nonempty          = 4'b1000;
    hol_age[3*AW +: AW] = 8'd11;
    #4;
    chk(cell_valid && cell_eager && cell_q == 2'd3, "R5 age below limit", cell_valid, 1);
    step();
    hol_age[3*AW +: AW] = 8'd12;
    #4;
    chk(!cell_valid, "R5 age at limit", cell_valid, 0);
    chk(req_valid && req_q == 2'd3, "R6 aged queue requests", req_valid, 1);
    step();
    cfg_rtt             = 8'd7;
    hol_age[3*AW +: AW] = 8'd9;
    #4;
    chk(cell_valid && cell_eager, "R5 odd round trip, age 9", cell_valid, 1);
    step();
    hol_age[3*AW +: AW] = 8'd10;
    #4;
    chk(!cell_valid, "R5 odd round trip, age 10", cell_valid, 0);
    step();
    drain("S4");

    // Scenario 5: grant and request in one cycle, stray grant.
    do_reset(0, 2, 8);
    q_nonempty = 4'b0001;
    req_ready  = 1'b1;
    push_req(0, 0, "R1 first request");
    step();
    grant_valid = 1'b1;
    grant_q     = 2'd0;
    push_req(0, 1, "R1 grant and request together");
    step();
    grant_valid = 1'b1;
    grant_q     = 2'd3;
    #4;
    chk(!req_valid, "R1 net outstanding at bound", req_valid, 0);
    chk(cell_valid && !cell_eager && cell_q == 2'd0, "R3 granted cell offered",
        cell_valid, 1);
    step();
    q_nonempty = 4'b1000;
    req_ready  = 1'b0;
    cell_ready = 1'b1;
    #4;
    chk(!cell_valid, "R11 stray grant dropped", cell_valid, 0);
    chk(req_valid && req_q == 2'd3, "R11 queue still requests", int'(req_q), 3);
    step();
    q_nonempty = '0;
    step();
    drain("S5");

    done = 1'b1;
    summary();
    $finish;
  end

endmodule